// File: doc/BRIEF.md
# Shared-Buffer Admission Controller

This block decides, frame by frame, whether a shared-buffer packet switch may take in a new frame. It keeps a buffer-occupancy count for every output port and one more count for buffers held by multicast frames. An arriving frame names its destination ports as a bit mask and carries a multicast flag. The block returns an accept or drop verdict in the same cycle. Later buffer releases, tagged the same way, bring the counts back down.

A port whose count climbs above a programmable high mark becomes blacklisted. Every frame aimed at that port is then dropped until the count falls below a separate, lower mark. Frames to other ports keep flowing, so one congested port cannot starve the rest. Multicast frames also face a shared cap on the multicast count, which keeps them from using up the buffers that unicast traffic needs. The high mark, the low mark and the multicast cap are written through a small configuration port. All three reset to the all-ones value, so nothing is dropped by default.

The request channel has no back-pressure. A request is presented with `req_valid` and is judged in that cycle, and the verdict is `req_accept`. The block never stalls the sender. A dropped frame is simply not counted. Release events are likewise taken unconditionally in the cycle they appear.

Top module: `bac_admit`

## Requirements
- R1: At each clock edge, a port's count rises by one when an accepted request has that port's bit set in `req_dest`, and falls by one when `rel_valid` is high with that port's bit set in `rel_dest`. When both happen in the same cycle, the count is unchanged.
- R2: After the edge at which a port's count becomes greater than the high mark, that port's `blacklist` bit reads 1.
- R3: A request whose `req_dest` includes any blacklisted port gets `req_accept`=0 in that same cycle. Requests to ports that are not blacklisted are still accepted.
- R4: A blacklist bit stays set while the port's count is at or above the low mark. It clears at the edge where the count becomes less than the low mark.
- R5: A request with `req_mcast`=1 is dropped while the multicast count is greater than or equal to the multicast cap. A request with `req_mcast`=0 is never blocked by the cap. `rel_valid` with `rel_mcast`=1 lowers the multicast count by one.
- R6: An accepted multicast request raises the multicast count by exactly one and raises the count of every port set in `req_dest`. If any destination port is blacklisted, the whole request is dropped.
- R7: A dropped request changes no count.
- R8: A release on a count that is already zero leaves it at zero and sets `underflow_err`. The flag then stays 1 until reset.
- R9: `req_accept` is combinational from the current inputs and state. It is 0 whenever `req_valid` is 0 or `req_dest` is all zeros.
- R10: Synchronous reset `rst` clears all counts, all `blacklist` bits and `underflow_err`, and loads all three limits with all ones. A write with `cfg_wr`=1 sets one limit at the next edge, chosen by `cfg_sel`: 0 = high mark, 1 = low mark, 2 = multicast cap. Code 3 writes nothing.
- R11: A request is dropped when any of its destination counts, or the multicast count for a multicast request, already holds the all-ones value (2047 at the default width). Counts never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Limit write strobe |
| cfg_sel | input | 2 | Limit select: 0 high mark, 1 low mark, 2 multicast cap |
| cfg_wdata | input | CW | Value to write into the selected limit |
| req_valid | input | 1 | A frame asks for admission this cycle |
| req_dest | input | NPORT | Destination port mask of the frame |
| req_mcast | input | 1 | Frame is multicast |
| req_accept | output | 1 | Verdict: 1 admit, 0 drop |
| rel_valid | input | 1 | A buffer release occurs this cycle |
| rel_dest | input | NPORT | Ports whose counts are released |
| rel_mcast | input | 1 | Release also lowers the multicast count |
| blacklist | output | NPORT | Per-port blacklist status |
| underflow_err | output | 1 | Sticky flag for a release at zero |

## Verification
The internal counts are not visible at the ports, so a wrong count shows up as a blacklist bit or a verdict that changes at the wrong edge. The bench therefore raises each count to the edge where its bit must set and confirms that the bit changes exactly there. A request that was wrongly counted, or a release that wrapped, moves that edge earlier. A count that wrapped shows up at once as an immediate blacklist or as a missing saturation drop. A wrong multicast count shows up on the next multicast request as a verdict of the wrong polarity.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    LIM_HIGH  = 2'd0,
    LIM_LOW   = 2'd1,
    LIM_MCAP  = 2'd2,
    LIM_NONE  = 2'd3
  } lim_sel_e;
endpackage

// File: rtl/bac_limits.sv
module bac_limits #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] high_mark,
  output logic [CW-1:0] low_mark,
  output logic [CW-1:0] mc_cap
);
  import bac_pkg::*;

  localparam logic [CW-1:0] LIM_MAX = '1;

  lim_sel_e sel_e;
  assign sel_e = lim_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      high_mark <= LIM_MAX;
      low_mark  <= LIM_MAX;
      mc_cap    <= LIM_MAX;
    end else if (wr) begin
      case (sel_e)
        LIM_HIGH: high_mark <= wdata;
        LIM_LOW:  low_mark  <= wdata;
        LIM_MCAP: mc_cap    <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/bac_updown.sv
module bac_updown #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          underflow
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic empty;
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_MAX);

  always_comb begin
    cnt_nxt   = cnt;
    underflow = 1'b0;
    if (inc && !dec) begin
      if (!full) cnt_nxt = cnt + ONE;
    end else if (dec && !inc) begin
      if (empty) underflow = 1'b1;
      else       cnt_nxt   = cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/bac_port_track.sv
module bac_port_track #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] high_mark,
  input  logic [CW-1:0] low_mark,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          underflow,
  output logic          bl
);
  logic [CW-1:0] cnt_nxt;
  logic          bl_nxt;

  bac_updown #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .inc       (inc),
    .dec       (dec),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .full      (full),
    .underflow (underflow)
  );

  // hysteresis: enter above the high mark, leave below the low mark
  always_comb begin
    if (bl) bl_nxt = !(cnt_nxt < low_mark);
    else    bl_nxt = (cnt_nxt > high_mark);
  end

  always_ff @(posedge clk) begin
    if (rst) bl <= 1'b0;
    else     bl <= bl_nxt;
  end
endmodule

// File: rtl/bac_admit.sv
module bac_admit #(
  parameter int NPORT = 12,
  parameter int CW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic             req_valid,
  input  logic [NPORT-1:0] req_dest,
  input  logic             req_mcast,
  output logic             req_accept,
  input  logic             rel_valid,
  input  logic [NPORT-1:0] rel_dest,
  input  logic             rel_mcast,
  output logic [NPORT-1:0] blacklist,
  output logic             underflow_err
);
  logic [CW-1:0] high_mark, low_mark, mc_cap;

  bac_limits #(.CW(CW)) u_lim (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .high_mark (high_mark),
    .low_mark  (low_mark),
    .mc_cap    (mc_cap)
  );

  logic [NPORT-1:0][CW-1:0] port_cnt;
  logic [NPORT-1:0]         port_inc, port_dec, port_full, port_uf;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_inc[p] = req_accept && req_dest[p];
    assign port_dec[p] = rel_valid && rel_dest[p];

    bac_port_track #(.CW(CW)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .inc       (port_inc[p]),
      .dec       (port_dec[p]),
      .high_mark (high_mark),
      .low_mark  (low_mark),
      .cnt       (port_cnt[p]),
      .full      (port_full[p]),
      .underflow (port_uf[p]),
      .bl        (blacklist[p])
    );
  end

  logic [CW-1:0] mc_cnt, mc_nxt;
  logic          mc_inc, mc_dec, mc_full, mc_uf;

  assign mc_inc = req_accept && req_mcast;
  assign mc_dec = rel_valid && rel_mcast;

  bac_updown #(.CW(CW)) u_mc (
    .clk       (clk),
    .rst       (rst),
    .inc       (mc_inc),
    .dec       (mc_dec),
    .cnt       (mc_cnt),
    .cnt_nxt   (mc_nxt),
    .full      (mc_full),
    .underflow (mc_uf)
  );

  // admission verdict, purely from this cycle's request and held state
  logic dest_any, bl_hit, full_hit, mc_block;
  assign dest_any   = |req_dest;
  assign bl_hit     = |(req_dest & blacklist);
  assign full_hit   = |(req_dest & port_full);
  assign mc_block   = req_mcast && (mc_full || (mc_cnt >= mc_cap));
  assign req_accept = req_valid && dest_any && !bl_hit && !full_hit && !mc_block;

  always_ff @(posedge clk) begin
    if (rst)                       underflow_err <= 1'b0;
    else if ((|port_uf) || mc_uf)  underflow_err <= 1'b1;
  end
endmodule

// File: rtl/bac_admit_chk.sv
module bac_admit_chk #(
  parameter int NPORT = 12,
  parameter int CW    = 11
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_wr,
  input logic                     req_valid,
  input logic [NPORT-1:0]         req_dest,
  input logic                     req_mcast,
  input logic                     req_accept,
  input logic [NPORT-1:0]         blacklist,
  input logic                     underflow_err,
  input logic [NPORT-1:0][CW-1:0] port_cnt,
  input logic [NPORT-1:0]         port_inc,
  input logic [NPORT-1:0]         port_dec,
  input logic [CW-1:0]            high_mark,
  input logic [CW-1:0]            low_mark,
  input logic [CW-1:0]            mc_cap,
  input logic [CW-1:0]            mc_cnt,
  input logic [CW-1:0]            mc_nxt
);
  // R9
  accept_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> (req_valid && (req_dest != '0)));

  // R3
  bl_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ((req_dest & blacklist) != '0)) |-> !req_accept);

  // R5
  mc_cap_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mcast && (mc_cnt >= mc_cap)) |-> !req_accept);

  // R5
  mc_grow_below_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_nxt > mc_cnt) |-> (mc_cnt < mc_cap));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  for (genvar p = 0; p < NPORT; p++) begin : g_pchk
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (port_inc[p] && port_dec[p]) |=> $stable(port_cnt[p]));

    // R2
    bl_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(cfg_wr) && (port_cnt[p] > high_mark)) |-> blacklist[p]);

    // R4
    bl_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(cfg_wr) && $fell(blacklist[p])) |-> (port_cnt[p] < low_mark));

    // R11
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (port_cnt[p] == '1) |=> (port_cnt[p] != '0));
  end
endmodule

bind bac_admit bac_admit_chk #(.NPORT(NPORT), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_wr        (cfg_wr),
  .req_valid     (req_valid),
  .req_dest      (req_dest),
  .req_mcast     (req_mcast),
  .req_accept    (req_accept),
  .blacklist     (blacklist),
  .underflow_err (underflow_err),
  .port_cnt      (port_cnt),
  .port_inc      (port_inc),
  .port_dec      (port_dec),
  .high_mark     (high_mark),
  .low_mark      (low_mark),
  .mc_cap        (mc_cap),
  .mc_cnt        (mc_cnt),
  .mc_nxt        (mc_nxt)
);

// File: tb/test_bac_admit.sv
module test_bac_admit;
  localparam int NPORT = 12;
  localparam int CW    = 11;
  localparam int NVEC  = 18;
  localparam int VW    = 41;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [CW-1:0]    cfg_wdata = '0;
  logic             req_valid = 1'b0;
  logic [NPORT-1:0] req_dest = '0;
  logic             req_mcast = 1'b0;
  logic             req_accept;
  logic             rel_valid = 1'b0;
  logic [NPORT-1:0] rel_dest = '0;
  logic             rel_mcast = 1'b0;
  logic [NPORT-1:0] blacklist;
  logic             underflow_err;

  always #2 clk = ~clk;

  bac_admit #(.NPORT(NPORT), .CW(CW)) i_bac_admit (
    .clk, .rst, .cfg_wr, .cfg_sel, .cfg_wdata,
    .req_valid, .req_dest, .req_mcast, .req_accept,
    .rel_valid, .rel_dest, .rel_mcast,
    .blacklist, .underflow_err
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {req_valid, req_dest, req_mcast, rel_valid, rel_dest, rel_mcast, exp_accept, exp_blacklist}
  // limits: high=2, low=1, multicast cap=2
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1,12'h001,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h000}, // 0 R1 p0=1
    {1'b1,12'h001,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h000}, // 1 p0=2
    {1'b1,12'h001,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h001}, // 2 R2 p0=3 > 2
    {1'b1,12'h001,1'b0, 1'b0,12'h000,1'b0, 1'b0,12'h001}, // 3 R3 dropped
    {1'b1,12'h002,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h001}, // 4 R3 p1 flows, p1=1
    {1'b0,12'h000,1'b0, 1'b1,12'h001,1'b0, 1'b0,12'h001}, // 5 R4 p0=2 stays
    {1'b0,12'h000,1'b0, 1'b1,12'h001,1'b0, 1'b0,12'h001}, // 6 R4 p0=1 stays
    {1'b1,12'h001,1'b0, 1'b1,12'h001,1'b0, 1'b0,12'h000}, // 7 R4 drop, p0=0 clears
    {1'b1,12'h001,1'b0, 1'b1,12'h001,1'b0, 1'b1,12'h000}, // 8 R1 both, p0 stays 0
    {1'b1,12'h006,1'b1, 1'b0,12'h000,1'b0, 1'b1,12'h000}, // 9 R6 mc=1 p1=2 p2=1
    {1'b1,12'h004,1'b1, 1'b0,12'h000,1'b0, 1'b1,12'h000}, // 10 mc=2 p2=2
    {1'b1,12'h008,1'b1, 1'b0,12'h000,1'b0, 1'b0,12'h000}, // 11 R5 cap hit, R7 p3 stays 0
    {1'b1,12'h004,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h004}, // 12 R5 unicast ok, p2=3
    {1'b0,12'h000,1'b0, 1'b1,12'h000,1'b1, 1'b0,12'h004}, // 13 R5 mc release, mc=1
    {1'b1,12'h00C,1'b1, 1'b0,12'h000,1'b0, 1'b0,12'h004}, // 14 R6 p2 blacklisted
    {1'b1,12'h008,1'b1, 1'b0,12'h000,1'b0, 1'b1,12'h004}, // 15 mc=2 p3=1
    {1'b1,12'h008,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h004}, // 16 R7 p3=2
    {1'b1,12'h008,1'b0, 1'b0,12'h000,1'b0, 1'b1,12'h00C}  // 17 R7 p3=3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_dest = '0; req_mcast = 1'b0;
    rel_valid = 1'b0; rel_dest = '0; rel_mcast = 1'b0;
    cfg_wr = 1'b0;
  endtask

  task automatic write_lim(input logic [1:0] sel, input logic [CW-1:0] val);
    @(negedge clk);
    idle();
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one cycle, check verdict before the edge, return to negedge
  task automatic step(input logic rv, input logic [NPORT-1:0] d, input logic m,
                      input logic lv, input logic [NPORT-1:0] ld, input logic lm,
                      output logic acc);
    @(negedge clk);
    req_valid = rv; req_dest = d; req_mcast = m;
    rel_valid = lv; rel_dest = ld; rel_mcast = lm;
    #1 acc = req_accept;
  endtask

  initial begin
    logic acc;
    do_reset();
    #1;
    chk("R10 reset blacklist", 32'(blacklist), 32'h0);
    chk("R10 reset underflow_err", 32'(underflow_err), 32'h0);
    step(1'b0, 12'h001, 1'b0, 1'b0, '0, 1'b0, acc);
    chk("R9 valid low gives no accept", 32'(acc), 32'h0);
    step(1'b1, 12'h000, 1'b0, 1'b0, '0, 1'b0, acc);
    chk("R9 empty mask gives no accept", 32'(acc), 32'h0);
    step(1'b1, 12'h001, 1'b1, 1'b0, '0, 1'b0, acc);
    chk("R10 default limits admit multicast", 32'(acc), 32'h1);
    step(1'b0, '0, 1'b0, 1'b1, 12'h001, 1'b1, acc);

    write_lim(2'd0, 11'd2);
    write_lim(2'd1, 11'd1);
    write_lim(2'd2, 11'd2);
    write_lim(2'd3, 11'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      step(e[40], e[39:28], e[27], e[26], e[25:14], e[13], acc);
      chk($sformatf("table vec %0d accept (R1/R3/R5/R6/R7)", v), 32'(acc), 32'(e[12]));
      @(posedge clk); #1;
      chk($sformatf("table vec %0d blacklist (R2/R4/R6/R7)", v), 32'(blacklist), 32'(e[11:0]));
    end
    chk("R8 no underflow yet", 32'(underflow_err), 32'h0);

    // R8: release on empty port 11, then three admits needed to blacklist it
    step(1'b0, '0, 1'b0, 1'b1, 12'h800, 1'b0, acc);
    @(posedge clk); #1;
    chk("R8 underflow flag set", 32'(underflow_err), 32'h1);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 12'h800, 1'b0, 1'b0, '0, 1'b0, acc);
      chk("R8 admit after saturated release", 32'(acc), 32'h1);
      @(posedge clk); #1;
      chk("R8 count held at zero", 32'(blacklist[11]), (k == 2) ? 32'h1 : 32'h0);
    end
    chk("R8 flag sticky", 32'(underflow_err), 32'h1);

    // R10 reset restores limits and clears state
    do_reset();
    #1;
    chk("R10 blacklist cleared", 32'(blacklist), 32'h0);
    chk("R10 underflow_err cleared", 32'(underflow_err), 32'h0);

    // R11: fill port 5 to all ones with default limits
    for (int k = 0; k < 2047; k++)
      step(1'b1, 12'h020, 1'b0, 1'b0, '0, 1'b0, acc);
    chk("R10 default limits still admit at 2046", 32'(acc), 32'h1);
    step(1'b1, 12'h020, 1'b0, 1'b0, '0, 1'b0, acc);
    chk("R11 drop at full count", 32'(acc), 32'h0);
    chk("R11 no blacklist at full with max high mark", 32'(blacklist), 32'h0);
    step(1'b0, '0, 1'b0, 1'b1, 12'h020, 1'b0, acc);
    step(1'b1, 12'h020, 1'b0, 1'b0, '0, 1'b0, acc);
    chk("R11 admit after one release", 32'(acc), 32'h1);
    chk("R11 no wrap underflow", 32'(underflow_err), 32'h0);

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule